// File: doc/BRIEF.md
# Tagged Translation Buffer with Used-Bit Replacement

This block is a small fully associative address translation buffer. Every slot holds an aligned virtual page base, a page size code, a partition number, a context number, a flag that marks the slot as a real-address mapping rather than a virtual one, and a 64-bit page descriptor. A lookup port compares one address against every slot in the same cycle. It returns whether a slot matched, which slot it was and that slot's descriptor.

A command port changes the contents, one operation per clock. An insert without an index picks its own slot, and an insert with an index writes exactly the slot it names. Three demap commands remove slots by page, by context or by partition, and a flush empties the whole buffer. Before any insert writes a slot, it removes every existing slot whose range overlaps the new one. A read port returns any slot's packed tag and its descriptor, so that software-visible state can be inspected. The block keeps a used bit for each slot and exposes these bits.

Top module: `tagged_tlb`

## Requirements
- R1: A lookup matches a slot when the slot is valid, the real flags are equal, the partitions are equal and the address falls inside the slot's page. For a virtual lookup the contexts must also be equal; a real lookup ignores the context. On a match, `lkHit` is 1, `lkIndex` gives the lowest matching slot and `lkData` gives its descriptor. `lkMulti` is 1 only when more than one slot matches.
- R2: An insert stores the virtual address rounded down to its page boundary. The page size is 2^(13+3*code) bytes, where code is the descriptor's bits 6:5.
- R3: When an insert overlaps existing slots, it first invalidates each of them that has the same real flag and partition, and also the same context when the new mapping is virtual. Slots that differ in any of these are kept.
- R4: An insert without an index (cmdOp 0) writes the lowest-numbered free slot. A slot counts as free if it is invalid or if this same insert removes it.
- R5: When no slot is free, the insert searches from the slot after the last-replaced pointer and wraps around. It skips locked slots (descriptor bit 0) and does not consider the pointer's own slot. If every candidate is locked, it overwrites the highest-numbered slot. The pointer moves to the slot chosen, and only this search path moves it.
- R6: An insert at an index (cmdOp 1, `cmdIndex` below the slot count) writes that slot without any replacement search, and the overlap removal of R3 still applies.
- R7: An insert sets the written slot's used bit. A lookup with `lkUpdate` high that matches sets the matching slot's used bit, except in a cycle where `cmdValid` is high. Whenever the bits would become all ones, every bit except the one just set is cleared.
- R8: A demap of a page (cmdOp 2) invalidates the slots that a lookup with the command's address, partition, context and real flag would match.
- R9: A demap of a context (cmdOp 3) invalidates every valid slot with the given partition and context, including locked slots.
- R10: A demap of a partition (cmdOp 4) invalidates only the unlocked slots of that partition.
- R11: A flush (cmdOp 5) invalidates every slot and clears all used bits.
- R12: The read port returns all ones in both `rdTag` and `rdData` for an invalid slot. For a valid slot, `rdData` is the descriptor and `rdTag` is packed as follows: partition in bits 63:61, real flag in bit 60, the inverted size code in bits 57:56, the aligned address in bits 47:13 and the context in bits 12:0. All other bits are zero.
- R13: Descriptor layout: bit 0 locked, bit 1 privileged, bit 2 writable, bit 3 no-fault, bit 4 side-effect, bits 6:5 size code, bits 39:13 physical page. The block interprets only the locked bit and the size code and stores the word unchanged.
- R14: A synchronous reset invalidates every slot, clears all used bits and sets the last-replaced pointer to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Apply the command in this cycle |
| cmdOp | input | 3 | 0 insert, 1 insert at index, 2 demap page, 3 demap context, 4 demap partition, 5 flush |
| cmdVa | input | 48 | Command virtual address |
| cmdPart | input | 3 | Command partition |
| cmdCtx | input | 13 | Command context |
| cmdReal | input | 1 | Command real-address flag |
| cmdData | input | 64 | Descriptor to insert |
| cmdIndex | input | IDX_W | Slot for an insert at index |
| lkVa | input | 48 | Lookup address |
| lkPart | input | 3 | Lookup partition |
| lkCtx | input | 13 | Lookup context |
| lkReal | input | 1 | Lookup real-address flag |
| lkUpdate | input | 1 | Lookup is a genuine access that updates the used bits |
| lkHit | output | 1 | A slot matched |
| lkIndex | output | IDX_W | Lowest matching slot |
| lkData | output | 64 | Descriptor of the matching slot |
| lkMulti | output | 1 | More than one slot matched |
| rdIndex | input | IDX_W | Slot to read |
| rdTag | output | 64 | Packed tag of the slot |
| rdData | output | 64 | Descriptor of the slot |
| usedVec | output | NUM_ENTRIES | Used bit per slot |

## Verification
The hardest state to reach from the ports is a full buffer in which the round-robin search must step past locked slots or fall back to the highest slot. To get there, the bench fills all four slots through the free-slot path, which leaves the pointer at zero. It then locks chosen slots with inserts at an index, whose writes do not move the pointer. It follows with unindexed inserts at addresses that overlap nothing, so that the pointer's sequence can be predicted exactly. The used-bit saturation is reached the same way: the bench fills the buffer and then touches each slot with update lookups until the bits would all be set.

// File: rtl/tagged_tlb_pkg.sv
package tagged_tlb_pkg;
  localparam int VA_W      = 48;
  localparam int PART_W    = 3;
  localparam int CTX_W     = 13;
  localparam int SZ_W      = 2;
  localparam int IDX_MAX_W = 6;
  localparam int B_LOCK    = 0;
  localparam int B_SZ      = 5;

  typedef enum logic [2:0] {
    OP_INSERT     = 3'd0,
    OP_INSERT_AT  = 3'd1,
    OP_DEMAP_PAGE = 3'd2,
    OP_DEMAP_CTX  = 3'd3,
    OP_DEMAP_ALL  = 3'd4,
    OP_FLUSH      = 3'd5
  } tlb_op_e;

  typedef struct packed {
    logic                 wrEn;
    logic [IDX_MAX_W-1:0] wrIdx;
    logic                 clrAll;
  } tlb_strobe_t;

  function automatic logic [VA_W-1:0] pageMask(input logic [SZ_W-1:0] code);
    return (VA_W'(1) << (13 + 3 * int'(code))) - VA_W'(1);
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tagged_tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  tlb_strobe_t       st,
  input  logic [N-1:0]      killVec,
  input  logic [VA_W-1:0]   cmdVa,
  input  logic [PART_W-1:0] cmdPart,
  input  logic [CTX_W-1:0]  cmdCtx,
  input  logic              cmdReal,
  input  logic [63:0]       cmdData,
  input  logic [VA_W-1:0]   lkVa,
  input  logic [PART_W-1:0] lkPart,
  input  logic [CTX_W-1:0]  lkCtx,
  input  logic              lkReal,
  input  logic [IDX_W-1:0]  rdIndex,
  output logic [N-1:0]      conflVec,
  output logic [N-1:0]      pageVec,
  output logic [N-1:0]      ctxVec,
  output logic [N-1:0]      partVec,
  output logic [N-1:0]      validVec,
  output logic [N-1:0]      lockVec,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIndex,
  output logic [63:0]       lkData,
  output logic              lkMulti,
  output logic [63:0]       rdTag,
  output logic [63:0]       rdData
);
  logic [VA_W-1:0]   vaQ   [N];
  logic [PART_W-1:0] partQ [N];
  logic [CTX_W-1:0]  ctxQ  [N];
  logic              realQ [N];
  logic [63:0]       dataQ [N];
  logic [N-1:0]      validQ, hitVec, wrHot;

  logic [VA_W-1:0] newMask, newVa;
  assign newMask = pageMask(cmdData[B_SZ +: SZ_W]);
  assign newVa   = cmdVa & ~newMask;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [VA_W-1:0] eMask, bigMask;
    assign eMask   = pageMask(dataQ[i][B_SZ +: SZ_W]);
    assign bigMask = eMask | newMask;

    assign hitVec[i]   = validQ[i] && (realQ[i] == lkReal) && (partQ[i] == lkPart) &&
                         ((lkVa & ~eMask) == vaQ[i]) && (lkReal || (ctxQ[i] == lkCtx));
    assign pageVec[i]  = validQ[i] && (realQ[i] == cmdReal) && (partQ[i] == cmdPart) &&
                         ((cmdVa & ~eMask) == vaQ[i]) && (cmdReal || (ctxQ[i] == cmdCtx));
    assign conflVec[i] = validQ[i] && (realQ[i] == cmdReal) && (partQ[i] == cmdPart) &&
                         ((vaQ[i] & ~bigMask) == (newVa & ~bigMask)) &&
                         (cmdReal || (ctxQ[i] == cmdCtx));
    assign ctxVec[i]   = validQ[i] && (partQ[i] == cmdPart) && (ctxQ[i] == cmdCtx);
    assign lockVec[i]  = dataQ[i][B_LOCK];
    assign partVec[i]  = validQ[i] && (partQ[i] == cmdPart) && !lockVec[i];
    assign wrHot[i]    = st.wrEn && (st.wrIdx == IDX_MAX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        validQ[i] <= 1'b0;
      end else if (wrHot[i]) begin
        validQ[i] <= 1'b1;
        vaQ[i]    <= newVa;
        partQ[i]  <= cmdPart;
        ctxQ[i]   <= cmdCtx;
        realQ[i]  <= cmdReal;
        dataQ[i]  <= cmdData;
      end else if (st.clrAll || killVec[i]) begin
        validQ[i] <= 1'b0;
      end
    end
  end

  assign validVec = validQ;

  always_comb begin
    lkHit   = |hitVec;
    lkIndex = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hitVec[i]) lkIndex = IDX_W'(i);
    end
    lkData  = lkHit ? dataQ[lkIndex] : '0;
    lkMulti = ($countones(hitVec) > 1);
  end

  logic             rdOk;
  logic [IDX_W-1:0] rdSel;
  always_comb begin
    rdSel = (int'(rdIndex) < N) ? rdIndex : '0;
    rdOk  = (int'(rdIndex) < N) && validQ[rdSel];
    if (rdOk) begin
      rdTag  = {partQ[rdSel], realQ[rdSel], 2'b00, ~dataQ[rdSel][B_SZ +: SZ_W], 8'h00,
                vaQ[rdSel][VA_W-1:13], ctxQ[rdSel]};
      rdData = dataQ[rdSel];
    end else begin
      rdTag  = '1;
      rdData = '1;
    end
  end

  // R6: a write to an existing slot leaves it valid one cycle later
  p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
    (st.wrEn && (int'(st.wrIdx) < N)) |=> |(validQ & $past(wrHot)));
  // R11: a flush leaves no valid slot
  p_flush_empties_r11: assert property (@(posedge clk) disable iff (rst)
    st.clrAll |=> (validQ == '0));
  // R3: removed slots that are not rewritten stay invalid
  p_kill_sticks_r3: assert property (@(posedge clk) disable iff (rst)
    (|killVec) |=> ((validQ & $past(killVec & ~wrHot)) == '0));
  // R1: overlap removal keeps every lookup to at most one match
  p_unique_hit_r1: assert property (@(posedge clk) disable iff (rst) !lkMulti);
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tagged_tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdValid,
  input  tlb_op_e          op,
  input  logic [IDX_W-1:0] cmdIndex,
  input  logic [N-1:0]     conflVec,
  input  logic [N-1:0]     pageVec,
  input  logic [N-1:0]     ctxVec,
  input  logic [N-1:0]     partVec,
  input  logic [N-1:0]     validVec,
  input  logic [N-1:0]     lockVec,
  input  logic             lkHit,
  input  logic [IDX_W-1:0] lkIndex,
  input  logic             lkUpdate,
  output tlb_strobe_t      st,
  output logic [N-1:0]     killVec,
  output logic [N-1:0]     usedVec
);
  logic [IDX_W-1:0] lastRepQ, rrIdx, freeIdx, insIdx;
  logic [N-1:0]     freeVec, usedQ, usedBase, touch, usedNext;
  logic             anyFree, useRr, isIns;

  always_comb begin
    freeVec = ~validVec | conflVec;
    anyFree = |freeVec;
    freeIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (freeVec[i]) freeIdx = IDX_W'(i);
    end
  end

  always_comb begin
    logic found;
    found = 1'b0;
    rrIdx = IDX_W'(N - 1);
    for (int k = 1; k < N; k++) begin
      int c;
      c = (int'(lastRepQ) + k) % N;
      if (!found && !lockVec[c]) begin
        rrIdx = IDX_W'(c);
        found = 1'b1;
      end
    end
  end

  assign isIns  = cmdValid && (op == OP_INSERT || op == OP_INSERT_AT);
  assign useRr  = cmdValid && (op == OP_INSERT) && !anyFree;
  assign insIdx = (op == OP_INSERT_AT) ? cmdIndex : (anyFree ? freeIdx : rrIdx);

  always_comb begin
    st      = '0;
    killVec = '0;
    if (cmdValid) begin
      case (op)
        OP_INSERT, OP_INSERT_AT: begin
          killVec  = conflVec;
          st.wrEn  = 1'b1;
          st.wrIdx = IDX_MAX_W'(insIdx);
        end
        OP_DEMAP_PAGE: killVec   = pageVec;
        OP_DEMAP_CTX:  killVec   = ctxVec;
        OP_DEMAP_ALL:  killVec   = partVec;
        OP_FLUSH:      st.clrAll = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    usedBase = st.clrAll ? '0 : (usedQ & ~killVec);
    touch    = '0;
    if (isIns) begin
      for (int i = 0; i < N; i++) touch[i] = (st.wrIdx == IDX_MAX_W'(i));
    end else if (!cmdValid && lkHit && lkUpdate) begin
      touch[lkIndex] = 1'b1;
    end
    usedNext = usedBase | touch;
    if ((|touch) && (&usedNext)) usedNext = touch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      usedQ    <= '0;
      lastRepQ <= '0;
    end else begin
      usedQ <= usedNext;
      if (useRr) lastRepQ <= rrIdx;
    end
  end

  assign usedVec = usedQ;

  // R7: the used bits never rest all set
  p_used_sparse_r7: assert property (@(posedge clk) disable iff (rst)
    (N == 1) || !(&usedQ));
  // R5: only a search-path insert moves the replacement pointer
  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(cmdValid && op == OP_INSERT) |=> $stable(lastRepQ));
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
  import tagged_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmdValid,
  input  logic [2:0]             cmdOp,
  input  logic [47:0]            cmdVa,
  input  logic [2:0]             cmdPart,
  input  logic [12:0]            cmdCtx,
  input  logic                   cmdReal,
  input  logic [63:0]            cmdData,
  input  logic [IDX_W-1:0]       cmdIndex,
  input  logic [47:0]            lkVa,
  input  logic [2:0]             lkPart,
  input  logic [12:0]            lkCtx,
  input  logic                   lkReal,
  input  logic                   lkUpdate,
  output logic                   lkHit,
  output logic [IDX_W-1:0]       lkIndex,
  output logic [63:0]            lkData,
  output logic                   lkMulti,
  input  logic [IDX_W-1:0]       rdIndex,
  output logic [63:0]            rdTag,
  output logic [63:0]            rdData,
  output logic [NUM_ENTRIES-1:0] usedVec
);
  tlb_strobe_t            st;
  logic [NUM_ENTRIES-1:0] killVec, conflVec, pageVec, ctxVec, partVec, validVec, lockVec;
  tlb_op_e                op;
  assign op = tlb_op_e'(cmdOp);

  tlb_ctrl #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .op(op), .cmdIndex(cmdIndex),
    .conflVec(conflVec), .pageVec(pageVec), .ctxVec(ctxVec), .partVec(partVec),
    .validVec(validVec), .lockVec(lockVec), .lkHit(lkHit), .lkIndex(lkIndex),
    .lkUpdate(lkUpdate), .st(st), .killVec(killVec), .usedVec(usedVec)
  );

  tlb_store #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .st(st), .killVec(killVec),
    .cmdVa(cmdVa), .cmdPart(cmdPart), .cmdCtx(cmdCtx), .cmdReal(cmdReal), .cmdData(cmdData),
    .lkVa(lkVa), .lkPart(lkPart), .lkCtx(lkCtx), .lkReal(lkReal), .rdIndex(rdIndex),
    .conflVec(conflVec), .pageVec(pageVec), .ctxVec(ctxVec), .partVec(partVec),
    .validVec(validVec), .lockVec(lockVec), .lkHit(lkHit), .lkIndex(lkIndex),
    .lkData(lkData), .lkMulti(lkMulti), .rdTag(rdTag), .rdData(rdData)
  );
endmodule

// File: tb/tb_tagged_tlb.sv
module tb_tagged_tlb;
  localparam int N  = 4;
  localparam int IW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cmdValid = 1'b0, cmdReal = 1'b0, lkReal = 1'b0, lkUpdate = 1'b0;
  logic [2:0]  cmdOp = '0, cmdPart = '0, lkPart = '0;
  logic [47:0] cmdVa = '0, lkVa = '0;
  logic [12:0] cmdCtx = '0, lkCtx = '0;
  logic [63:0] cmdData = '0;
  logic [IW-1:0] cmdIndex = '0, rdIndex = '0;
  logic        lkHit, lkMulti;
  logic [IW-1:0] lkIndex;
  logic [63:0] lkData, rdTag, rdData;
  logic [N-1:0] usedVec;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  tagged_tlb #(.NUM_ENTRIES(N)) dut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdVa(cmdVa),
    .cmdPart(cmdPart), .cmdCtx(cmdCtx), .cmdReal(cmdReal), .cmdData(cmdData),
    .cmdIndex(cmdIndex), .lkVa(lkVa), .lkPart(lkPart), .lkCtx(lkCtx), .lkReal(lkReal),
    .lkUpdate(lkUpdate), .lkHit(lkHit), .lkIndex(lkIndex), .lkData(lkData),
    .lkMulti(lkMulti), .rdIndex(rdIndex), .rdTag(rdTag), .rdData(rdData), .usedVec(usedVec)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] tagOf(input int part, input int rl, input int code,
                                        input logic [47:0] va, input int ctx);
    logic [47:0] al;
    logic [1:0]  c;
    al = va & ~((48'd1 << (13 + 3 * code)) - 48'd1);
    c  = 2'(code);
    return {3'(part), 1'(rl), 2'b00, ~c, 8'h00, al[47:13], 13'(ctx)};
  endfunction

  function automatic logic [63:0] dat(input logic [39:0] pa, input int code, input int lock);
    return {24'h0, pa[39:13], 6'h0, 2'(code), 4'h0, 1'(lock)};
  endfunction

  task automatic issue(input int op, input logic [47:0] va, input int part, input int ctx,
                       input int rl, input logic [63:0] d, input int idx);
    @(negedge clk);
    cmdOp = 3'(op); cmdVa = va; cmdPart = 3'(part); cmdCtx = 13'(ctx);
    cmdReal = 1'(rl); cmdData = d; cmdIndex = IW'(idx); cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    #1;
  endtask

  task automatic expRd(input string req, input int idx, input logic [63:0] t, input logic [63:0] d);
    rdIndex = IW'(idx);
    #1;
    check(req, rdTag, t);
    check(req, rdData, d);
  endtask

  task automatic probe(input string req, input logic [47:0] va, input int part, input int ctx,
                       input int rl, input int eHit, input int eIdx, input logic [63:0] eData);
    lkVa = va; lkPart = 3'(part); lkCtx = 13'(ctx); lkReal = 1'(rl);
    #1;
    check(req, 64'(lkHit), 64'(eHit));
    if (eHit != 0) begin
      check(req, 64'(lkIndex), 64'(eIdx));
      check(req, lkData, eData);
    end
    check(req, 64'(lkMulti), 64'd0);
  endtask

  task automatic touch(input logic [47:0] va, input int part, input int ctx, input int rl);
    @(negedge clk);
    lkVa = va; lkPart = 3'(part); lkCtx = 13'(ctx); lkReal = 1'(rl); lkUpdate = 1'b1;
    @(negedge clk);
    lkUpdate = 1'b0;
    #1;
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d0, d1, d2, d3, dl, dB, dC;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R14 reset state
    for (int i = 0; i < N; i++) expRd("R14", i, '1, '1);
    check("R14", 64'(usedVec), 64'd0);
    probe("R14", 48'h0, 0, 0, 0, 0, 0, 0);

    // R2 R4 R12 R13: first insert, page code 1 (64 KiB)
    d0 = dat(40'h00_ABCD_0000, 1, 0) | 64'h6;
    issue(0, 48'h0000_1234_5FFF, 2, 'h55, 0, d0, 0);
    expRd("R2", 0, tagOf(2, 0, 1, 48'h1234_0000, 'h55), d0);
    check("R12", {16'h0, rdTag[47:0]} & 64'hFFFF_FFFF_E000, 64'h1234_0000);
    check("R7", 64'(usedVec), 64'b0001);

    // R1 lookup sweep around the page
    probe("R1", 48'h1234_0000, 2, 'h55, 0, 1, 0, d0);
    probe("R1", 48'h1234_FFFF, 2, 'h55, 0, 1, 0, d0);
    probe("R1", 48'h1233_FFFF, 2, 'h55, 0, 0, 0, 0);
    probe("R1", 48'h1235_0000, 2, 'h55, 0, 0, 0, 0);
    probe("R1", 48'h1234_0010, 3, 'h55, 0, 0, 0, 0);
    probe("R1", 48'h1234_0010, 2, 'h56, 0, 0, 0, 0);
    probe("R1", 48'h1234_0010, 2, 'h55, 1, 0, 0, 0);

    // R1 real entry ignores context
    d1 = dat(40'h11_0000_0000, 0, 0);
    issue(0, 48'h8000_0000, 2, 9, 1, d1, 0);
    probe("R1", 48'h8000_1FFF, 2, 'h1FF, 1, 1, 1, d1);
    probe("R1", 48'h8000_2000, 2, 9, 1, 0, 0, 0);
    check("R7", 64'(usedVec), 64'b0011);

    // R4 lowest free slot, R7 saturation
    d2 = dat(40'h22_0000_0000, 0, 0);
    d3 = dat(40'h33_0000_0000, 0, 0);
    issue(0, 48'h2000, 0, 1, 0, d2, 0);
    expRd("R4", 2, tagOf(0, 0, 0, 48'h2000, 1), d2);
    check("R7", 64'(usedVec), 64'b0111);
    issue(0, 48'h4000, 0, 1, 0, d3, 0);
    expRd("R4", 3, tagOf(0, 0, 0, 48'h4000, 1), d3);
    check("R7", 64'(usedVec), 64'b1000);

    // R7 lookup updates
    touch(48'h1234_0000, 2, 'h55, 0);
    check("R7", 64'(usedVec), 64'b1001);
    probe("R7", 48'h8000_0000, 2, 0, 1, 1, 1, d1);
    @(negedge clk); #1;
    check("R7", 64'(usedVec), 64'b1001);
    // command in the same cycle blocks the lookup update
    @(negedge clk);
    lkVa = 48'h8000_0000; lkPart = 3'd2; lkReal = 1'b1; lkUpdate = 1'b1;
    cmdOp = 3'd2; cmdVa = 48'h7777_0000; cmdPart = 3'd0; cmdCtx = 13'd1; cmdReal = 1'b0;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; lkUpdate = 1'b0;
    #1;
    check("R7", 64'(usedVec), 64'b1001);
    touch(48'h8000_0000, 2, 0, 1);
    check("R7", 64'(usedVec), 64'b1011);
    touch(48'h2000, 0, 1, 0);
    check("R7", 64'(usedVec), 64'b0100);

    // R5 round robin, R6 explicit index
    issue(0, 48'h10_0000, 0, 1, 0, d2, 0);
    expRd("R5", 1, tagOf(0, 0, 0, 48'h10_0000, 1), d2);
    dl = dat(40'h44_0000_0000, 0, 1);
    issue(1, 48'h20_0000, 0, 1, 0, dl, 2);
    expRd("R6", 2, tagOf(0, 0, 0, 48'h20_0000, 1), dl);
    issue(0, 48'h30_0000, 0, 1, 0, d3, 0);
    expRd("R5", 3, tagOf(0, 0, 0, 48'h30_0000, 1), d3);
    issue(0, 48'h40_0000, 0, 1, 0, d3, 0);
    expRd("R5", 0, tagOf(0, 0, 0, 48'h40_0000, 1), d3);
    issue(1, 48'h50_0000, 0, 1, 0, dl, 0);
    issue(1, 48'h60_0000, 0, 1, 0, dl, 1);
    issue(1, 48'h70_0000, 0, 1, 0, dl, 3);
    expRd("R6", 1, tagOf(0, 0, 0, 48'h60_0000, 1), dl);
    issue(0, 48'h80_0000, 0, 1, 0, d2, 0);
    expRd("R5", 3, tagOf(0, 0, 0, 48'h80_0000, 1), d2);
    expRd("R5", 2, tagOf(0, 0, 0, 48'h20_0000, 1), dl);

    // R11 flush
    issue(5, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < N; i++) expRd("R11", i, '1, '1);
    check("R11", 64'(usedVec), 64'd0);

    // R10 partition demap spares locked slots and other partitions
    issue(0, 48'h1000_0000, 1, 7, 0, d2, 0);
    issue(0, 48'h1100_0000, 1, 7, 0, dl, 0);
    issue(0, 48'h1200_0000, 2, 7, 0, d3, 0);
    issue(4, 0, 1, 0, 0, 0, 0);
    expRd("R10", 0, '1, '1);
    expRd("R10", 1, tagOf(1, 0, 0, 48'h1100_0000, 7), dl);
    expRd("R10", 2, tagOf(2, 0, 0, 48'h1200_0000, 7), d3);

    // R9 context demap removes locked slot of that partition only
    issue(3, 0, 1, 7, 0, 0, 0);
    expRd("R9", 1, '1, '1);
    expRd("R9", 2, tagOf(2, 0, 0, 48'h1200_0000, 7), d3);

    // R8 page demap
    issue(2, 48'h1200_0ABC, 2, 8, 0, 0, 0);
    expRd("R8", 2, tagOf(2, 0, 0, 48'h1200_0000, 7), d3);
    issue(2, 48'h1200_0ABC, 2, 7, 0, 0, 0);
    expRd("R8", 2, '1, '1);

    // R3 overlap removal
    issue(5, 0, 0, 0, 0, 0, 0);
    dC = dat(40'h55_0000_0000, 0, 0);
    dB = dat(40'h66_0000_0000, 1, 0);
    issue(0, 48'h2000, 0, 4, 0, dC, 0);
    issue(0, 48'h4000, 0, 3, 0, d2, 0);
    issue(0, 48'h0000, 0, 3, 0, dB, 0);
    expRd("R3", 0, tagOf(0, 0, 0, 48'h2000, 4), dC);
    expRd("R3", 1, tagOf(0, 0, 1, 48'h0, 3), dB);
    expRd("R3", 2, '1, '1);
    expRd("R3", 3, '1, '1);
    probe("R3", 48'h4000, 0, 3, 0, 1, 1, dB);
    probe("R3", 48'h2000, 0, 4, 0, 1, 0, dC);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule